// File: doc/BRIEF.md
# Serially Loaded Four-Tap FIR Filter

This block filters a stream of signed 6-bit samples with four signed 6-bit weights. It has no separate coefficient bus. After reset is released, the single 6-bit data port carries the four weights for a fixed window of four clock cycles. After that window the same port carries one new sample on every clock.

Each cycle the block multiplies every stored sample by its weight at full precision and adds the four products into a 14-bit signed total. It registers the upper eight bits of that total as the output. Dropping the six low bits floors the result toward negative infinity. The block does not round and does not saturate. The weights stay fixed until the next reset.

Top module: `fir_serial_top`

## Requirements
- R1: While `rst` is high (synchronous, active high), every clock clears the output register, the weight registers and the sample delay line to zero. `dout` reads 0 after any edge sampled with `rst` high.
- R2: The weight-load window covers exactly the first 4 clock edges with `rst` low. Once it closes, the port never writes a weight again until the next reset.
- R3: Weights arrive in descending tap order: the first word loaded becomes weight 3 and the fourth word becomes weight 0. Weight k multiplies the sample that is k positions old, so weight 0 scales the newest stored sample.
- R4: During the load window the delay line holds zeros. `dout` reads 0 throughout the window and after the first edge that follows it.
- R5: A sample is captured at the first edge after it is driven (edge n). It first contributes to `dout` after edge n+1.
- R6: `dout` is bits [13:6] of the 14-bit two's-complement sum of the four 12-bit signed products, which equals floor(sum/64). For example, a sum of -992 gives -16 (8'hF0).
- R7: The extreme operands never wrap. Four samples of -32 against four weights of -32 give 64 (8'h40). Four samples of +31 against four weights of -32 give -62 (8'hC2).
- R8: After the load window the weights hold their values while arbitrary samples stream through the port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; its release starts the load window |
| din | input | 6 | Shared two's-complement word: a weight during the load window, a sample afterwards |
| dout | output | 8 | Registered two's-complement filter result (sum bits [13:6]) |

## Verification
On every cycle, the assertions check the following: the load window closes once and stays closed, the weights stay frozen after it, the delay line stays empty while weights load, and the output is zero after reset and during loading. Other behaviour is visible only through the bench's scenarios, each compared against a reference convolution. These cover the descending load order, the mapping of each weight to a tap age, the two-edge latency, flooring of negative sums, and the extreme operand values.

// File: rtl/fir_pkg.sv
package fir_pkg;
    localparam int TAPS_DEF   = 4;
    localparam int SAMP_W_DEF = 6;
    localparam int OUT_W_DEF  = 8;
endpackage

// File: rtl/fir_coef_loader.sv
module fir_coef_loader #(
    parameter int TAPS   = fir_pkg::TAPS_DEF,
    parameter int COEF_W = fir_pkg::SAMP_W_DEF
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [COEF_W-1:0]                  din,
    output logic                               load_en,
    output logic [TAPS-1:0][COEF_W-1:0]        coef
);
    localparam int CNT_W = $clog2(TAPS + 1);

    typedef struct packed {
        logic [CNT_W-1:0]             cnt;
        logic [TAPS-1:0][COEF_W-1:0]  coef;
    } ld_t;

    ld_t st_d, st_q;

    // Weight chain: new word enters slot 0 and older words move up,
    // so the first word ends in the highest slot.
    always_comb begin
        st_d = st_q;
        if (st_q.cnt < CNT_W'(TAPS)) begin
            st_d.cnt     = st_q.cnt + 1'b1;
            st_d.coef[0] = din;
            for (int i = 1; i < TAPS; i++) begin
                st_d.coef[i] = st_q.coef[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign load_en = (st_q.cnt < CNT_W'(TAPS));
    assign coef    = st_q.coef;

    AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> !load_en);                                   // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_W'(TAPS));                                // R2
    AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(coef));                              // R8
endmodule

// File: rtl/fir_sample_line.sv
module fir_sample_line #(
    parameter int TAPS   = fir_pkg::TAPS_DEF,
    parameter int SAMP_W = fir_pkg::SAMP_W_DEF
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               shift_en,
    input  logic [SAMP_W-1:0]                  din,
    output logic [TAPS-1:0][SAMP_W-1:0]        taps
);
    typedef struct packed {
        logic [TAPS-1:0][SAMP_W-1:0] line;
    } ln_t;

    ln_t ln_d, ln_q;

    // Slot k holds the sample that is k positions old.
    always_comb begin
        ln_d = ln_q;
        if (shift_en) begin
            ln_d.line[0] = din;
            for (int i = 1; i < TAPS; i++) begin
                ln_d.line[i] = ln_q.line[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ln_q <= '0;
        else     ln_q <= ln_d;
    end

    assign taps = ln_q.line;

    AST_LINE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !shift_en |-> (ln_q.line == '0));                         // R4
endmodule

// File: rtl/fir_mac_sum.sv
module fir_mac_sum #(
    parameter int TAPS   = fir_pkg::TAPS_DEF,
    parameter int SAMP_W = fir_pkg::SAMP_W_DEF,
    parameter int OUT_W  = fir_pkg::OUT_W_DEF
) (
    input  logic [TAPS-1:0][SAMP_W-1:0] samp,
    input  logic [TAPS-1:0][SAMP_W-1:0] coef,
    output logic [OUT_W-1:0]            result
);
    localparam int PROD_W = 2 * SAMP_W;
    localparam int SUM_W  = PROD_W + $clog2(TAPS);
    localparam int DROP   = SUM_W - OUT_W;

    logic signed [PROD_W-1:0] prod [TAPS];
    logic signed [SUM_W-1:0]  acc;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign prod[k] = $signed(samp[k]) * $signed(coef[k]);
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            acc = acc + SUM_W'(prod[k]);
        end
    end

    // Arithmetic shift keeps the floor behaviour on negative sums.
    assign result = OUT_W'(acc >>> DROP);
endmodule

// File: rtl/fir_serial_top.sv
module fir_serial_top #(
    parameter int TAPS   = fir_pkg::TAPS_DEF,
    parameter int SAMP_W = fir_pkg::SAMP_W_DEF,
    parameter int OUT_W  = fir_pkg::OUT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SAMP_W-1:0] din,
    output logic [OUT_W-1:0]  dout
);
    typedef struct packed {
        logic [OUT_W-1:0] dout;
    } out_t;

    logic                              load_en;
    logic [TAPS-1:0][SAMP_W-1:0]       coef;
    logic [TAPS-1:0][SAMP_W-1:0]       taps;
    logic [OUT_W-1:0]                  mac_out;
    out_t                              out_d, out_q;

    fir_coef_loader #(.TAPS(TAPS), .COEF_W(SAMP_W)) u_loader (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .load_en (load_en),
        .coef    (coef)
    );

    fir_sample_line #(.TAPS(TAPS), .SAMP_W(SAMP_W)) u_line (
        .clk      (clk),
        .rst      (rst),
        .shift_en (!load_en),
        .din      (din),
        .taps     (taps)
    );

    fir_mac_sum #(.TAPS(TAPS), .SAMP_W(SAMP_W), .OUT_W(OUT_W)) u_mac (
        .samp   (taps),
        .coef   (coef),
        .result (mac_out)
    );

    always_comb begin
        out_d      = out_q;
        out_d.dout = mac_out;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign dout = out_q.dout;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (dout == '0));                                    // R1
    AST_QUIET_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (dout == '0));                                // R4
endmodule

// File: tb/fir_serial_top_bench.sv
`timescale 1ns/1ps
module fir_serial_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] din = '0;
    logic [7:0] dout;

    int errors  = 0;
    int checks  = 0;
    int coef [4];
    int hist [4];
    int pending = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    fir_serial_top u_fir_serial_top (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .dout (dout)
    );

    function automatic int model();
        int s = 0;
        for (int k = 0; k < 4; k++) s += coef[k] * hist[k];
        return s >>> 6;
    endfunction

    task automatic check(input string tag, input int exp);
        checks++;
        if (dout !== 8'(exp)) begin
            errors++;
            $display("FAIL %s: dout=%0d (0x%h) expected=%0d", tag, $signed(dout), dout, exp);
        end
    endtask

    // Drive one sample; check the output due from earlier samples.
    task automatic step(input int x, input string tag);
        @(negedge clk);
        check(tag, pending);
        pending = model();
        for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        din = 6'(x);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        din = 6'h15;
        repeat (3) @(negedge clk);
        check("R1", 0);
        for (int k = 0; k < 4; k++) hist[k] = 0;
        pending = 0;
    endtask

    task automatic t_load(input int c3, input int c2, input int c1, input int c0);
        int w [4];
        w[0] = c3; w[1] = c2; w[2] = c1; w[3] = c0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i == 0) rst = 1'b0;
            check("R4", 0);
            din = 6'(w[i]);
        end
        coef[3] = c3; coef[2] = c2; coef[1] = c1; coef[0] = c0;
    endtask

    task automatic t_impulse();
        t_reset();
        t_load(-32, 16, 31, 8);
        step(0, "R4");
        step(31, "R5");
        step(0, "R3");
        step(0, "R5");
        check("R5", 3);
        step(0, "R3");
        check("R3", 15);
        step(0, "R3");
        check("R3", 7);
        step(0, "R6");
        check("R6", -16);
        step(0, "R6");
        check("R6", 0);
    endtask

    task automatic t_extremes();
        t_reset();
        t_load(-32, -32, -32, -32);
        for (int i = 0; i < 6; i++) step(-32, "R7");
        check("R7", 64);
        for (int i = 0; i < 6; i++) step(31, "R7");
        check("R7", -62);
        for (int i = 0; i < 6; i++) step(-32, "R7");
        check("R7", 64);
    endtask

    task automatic t_stream(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            step(int'($urandom_range(63)) - 32, tag);
        end
    endtask

    task automatic t_reload();
        t_reset();
        t_load(5, -7, 12, -1);
        t_stream(150, "R2");
        t_reset();
        t_load(31, -32, 0, 27);
        t_stream(150, "R8");
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin
            coef[k] = 0;
            hist[k] = 0;
        end
        t_reset();
        t_impulse();
        t_extremes();
        t_reload();
        t_stream(100, "R6");
        t_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule